// File: doc/BRIEF.md
# Bridge Bus-Lock State Controller

This block tracks exclusive-access (bus lock) ownership for a bridge that joins one upstream serial link to several downstream parallel bus segments. It watches the outbound transaction descriptors the bridge forwards downstream, the responses of the downstream targets, the upstream unlock message and a strobe that says a completion has gone back upstream. From these it derives which segment, if any, holds the lock. It then drives the per-segment lock line, retries inbound memory traffic on the owning segment, holds back every other upstream-bound source and tells the inbound read prefetcher to stop.

A lock starts as a pending request when a locked memory read to an external target is forwarded. It becomes real only when that target answers with target-ready. It ends when the upstream unlock message arrives. There is one exception: a locked read that ends in a master or target abort ends the lock once its completion has been sent. Aborted writes keep the lock. For each abort, the block also produces the abort code that goes into the completion.

Top module: `bus_lock_ctrl`

## Requirements
- R1: After reset, the unit is idle. A forwarded memory read with its lock flag set, aimed at an external target (`ob_internal`=0) on segment s, creates a pending request. Bit s of `seg_locked` and `pf_stop` go high one cycle after a target-ready response (`rsp_trdy`) from segment s, and not before it.
- R2: While a lock is held, `up_unlock` clears `seg_locked` and `pf_stop` one cycle later.
- R3: While segment s is locked, `ib_retry[s]` follows `ib_mem_req[s]` in the same cycle. `ib_retry` stays low for every unlocked segment.
- R4: `pf_stop` is high exactly while some segment is locked. A pending request alone does not raise it.
- R5: While segment s is locked, any outbound cycle forwarded to s raises `lock_drive[s]`, even with its lock flag clear. An unlocked segment gets no `lock_drive` for unlocked cycles.
- R6: While a segment is locked, `up_block` is high for every other segment and `apic_block` is high. The other segments never show `seg_locked`.
- R7: A master or target abort on a locked read (`rsp_is_rd`=1) from the owning segment keeps `seg_locked` high until `cpl_sent`. It clears one cycle after `cpl_sent`.
- R8: A master or target abort on a write (`rsp_is_rd`=0) to the owning segment leaves the lock held.
- R9: One cycle after any abort strobe, `abort_valid` pulses for one cycle. `abort_code` is 8'h00 for a master abort and 8'h01 for a target abort. If both strobes arrive together, the master abort takes priority.
- R10: A locked read aimed at an internal target, or a locked cycle that is not a memory read, never creates a lock, even if target-ready follows.
- R11: A pending request whose target answers with retry (`rsp_retry`) or an abort, and no target-ready, returns the unit to idle. A later target-ready then creates no lock.
- R12: At most one segment is pending or locked at any time. A locked read to another segment during that time is ignored.
- R13: An active-low reset (`rst_n`=0) in the middle of a lock clears `seg_locked`, `pf_stop` and `abort_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ob_valid | input | 1 | Outbound descriptor forwarded this cycle |
| ob_lock | input | 1 | Outbound descriptor lock flag |
| ob_mem_rd | input | 1 | Outbound descriptor is a memory read |
| ob_internal | input | 1 | Outbound target is an internal function |
| ob_seg | input | SEG_W | Outbound target segment |
| rsp_trdy | input | 1 | Downstream target-ready response |
| rsp_retry | input | 1 | Downstream retry or disconnect without data |
| rsp_mabort | input | 1 | Downstream master abort |
| rsp_tabort | input | 1 | Downstream target abort |
| rsp_is_rd | input | 1 | The responding cycle is a read |
| rsp_seg | input | SEG_W | Segment that gave the response |
| up_unlock | input | 1 | Upstream unlock message received |
| cpl_sent | input | 1 | Completion sent upstream |
| ib_mem_req | input | NUM_SEG | Inbound memory request present, per segment |
| seg_locked | output | NUM_SEG | Segment holds the lock |
| lock_drive | output | NUM_SEG | Drive the downstream lock line on the current cycle |
| ib_retry | output | NUM_SEG | Retry the inbound memory request |
| up_block | output | NUM_SEG | Hold this segment's upstream-bound traffic |
| apic_block | output | 1 | Hold interrupt-controller upstream traffic |
| pf_stop | output | 1 | Stop issuing new inbound prefetch reads |
| abort_valid | output | 1 | Abort code is valid this cycle |
| abort_code | output | CODE_W | Completion abort code |

## Verification
A state error in this block shows at the ports one cycle after the edge that causes it. A lock taken too early or on the wrong segment raises `seg_locked`, `pf_stop` and `up_block` on the next cycle. A lock that is lost or kept too long is visible at once in `ib_retry` and `lock_drive` for the next forwarded or inbound cycle. The vector sequence walks pending, held and draining states across both segments, and it places an ignored request or a stray response between the steps of each one. That way a wrong owner or a missed transition differs from the expected value within one cycle.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_WAIT  = 2'd1,
      LK_HELD  = 2'd2,
      LK_DRAIN = 2'd3
   } lk_state_e;

   localparam int unsigned CODE_MASTER_ABORT = 0;
   localparam int unsigned CODE_TARGET_ABORT = 1;
endpackage

// File: rtl/lock_fsm.sv
module lock_fsm
   import bus_lock_pkg::*;
#(
   parameter int unsigned NUM_SEG = 2,
   parameter int unsigned SEG_W   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ob_valid,
   input  logic             ob_lock,
   input  logic             ob_mem_rd,
   input  logic             ob_internal,
   input  logic [SEG_W-1:0] ob_seg,
   input  logic             rsp_trdy,
   input  logic             rsp_retry,
   input  logic             rsp_mabort,
   input  logic             rsp_tabort,
   input  logic             rsp_is_rd,
   input  logic [SEG_W-1:0] rsp_seg,
   input  logic             up_unlock,
   input  logic             cpl_sent,
   output lk_state_e        state_o,
   output logic [SEG_W-1:0] owner_o,
   output logic             start_ok
);
   lk_state_e        state_q, state_d;
   logic [SEG_W-1:0] owner_q;
   logic             rsp_own, abort_any, seg_ok;

   assign seg_ok    = ({1'b0, ob_seg} < (SEG_W+1)'(NUM_SEG));
   assign start_ok  = (state_q == LK_IDLE) && ob_valid && ob_lock && ob_mem_rd
                      && !ob_internal && seg_ok;
   assign rsp_own   = (rsp_seg == owner_q);
   assign abort_any = rsp_mabort || rsp_tabort;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LK_IDLE:  if (start_ok) state_d = LK_WAIT;
         LK_WAIT: begin
            if (up_unlock)                                state_d = LK_IDLE;
            else if (rsp_own && rsp_trdy)                 state_d = LK_HELD;
            else if (rsp_own && (rsp_retry || abort_any)) state_d = LK_IDLE;
         end
         LK_HELD: begin
            if (up_unlock)                             state_d = LK_IDLE;
            else if (rsp_own && abort_any && rsp_is_rd) state_d = LK_DRAIN;
         end
         LK_DRAIN: if (up_unlock || cpl_sent) state_d = LK_IDLE;
         default:  state_d = LK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         owner_q <= '0;
      end else begin
         state_q <= state_d;
         if (start_ok) owner_q <= ob_seg;
      end
   end

   assign state_o = state_q;
   assign owner_o = owner_q;

   // R1: no lock without a target-ready from the owning segment
   a_r1_lock_needs_trdy: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LK_WAIT && !(rsp_trdy && rsp_own)) |=> state_q != LK_HELD);
   // R2: unlock message releases a held lock
   a_r2_unlock_release: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == LK_HELD || state_q == LK_DRAIN) && up_unlock) |=> state_q == LK_IDLE);
   // R7: draining lock ends after the completion is sent
   a_r7_drain_end: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LK_DRAIN && cpl_sent) |=> state_q == LK_IDLE);
   // R8: aborted write keeps the lock
   a_r8_write_abort_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LK_HELD && !up_unlock && rsp_own && abort_any && !rsp_is_rd)
      |=> state_q == LK_HELD);
   // R12: owner cannot change while busy
   a_r12_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != LK_IDLE) |=> $stable(owner_q));
endmodule

// File: rtl/lock_fanout.sv
module lock_fanout
   import bus_lock_pkg::*;
#(
   parameter int unsigned NUM_SEG = 2,
   parameter int unsigned SEG_W   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  lk_state_e          state,
   input  logic [SEG_W-1:0]   owner,
   input  logic               start_ok,
   input  logic               ob_valid,
   input  logic [SEG_W-1:0]   ob_seg,
   input  logic [NUM_SEG-1:0] ib_mem_req,
   output logic [NUM_SEG-1:0] seg_locked,
   output logic [NUM_SEG-1:0] lock_drive,
   output logic [NUM_SEG-1:0] ib_retry,
   output logic [NUM_SEG-1:0] up_block,
   output logic               apic_block,
   output logic               pf_stop
);
   logic held;
   assign held = (state == LK_HELD) || (state == LK_DRAIN);

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic is_owner, ob_here;
      assign is_owner      = (owner == SEG_W'(s));
      assign ob_here       = ob_valid && (ob_seg == SEG_W'(s));
      assign seg_locked[s] = held && is_owner;
      assign lock_drive[s] = ob_here && (seg_locked[s] || start_ok);
      assign ib_retry[s]   = ib_mem_req[s] && seg_locked[s];
      assign up_block[s]   = held && !is_owner;
   end

   assign apic_block = held;
   assign pf_stop    = held;

   // R12: at most one segment shows the lock
   a_r12_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(seg_locked));
   // R6: a locked segment is never also blocked from upstream
   a_r6_block_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_locked & up_block) == '0);
endmodule

// File: rtl/abort_encoder.sv
module abort_encoder
   import bus_lock_pkg::*;
#(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_mabort,
   input  logic              rsp_tabort,
   output logic              abort_valid,
   output logic [CODE_W-1:0] abort_code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort_valid <= 1'b0;
         abort_code  <= '0;
      end else begin
         abort_valid <= rsp_mabort || rsp_tabort;
         if (rsp_mabort)      abort_code <= CODE_W'(CODE_MASTER_ABORT);
         else if (rsp_tabort) abort_code <= CODE_W'(CODE_TARGET_ABORT);
      end
   end

   // R9: target abort alone yields code 1 next cycle
   a_r9_target_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_tabort && !rsp_mabort) |=> (abort_valid && abort_code == CODE_W'(1)));
   // R9: master abort yields code 0 next cycle
   a_r9_master_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_mabort |=> (abort_valid && abort_code == '0));
endmodule

// File: rtl/bus_lock_ctrl.sv
module bus_lock_ctrl
   import bus_lock_pkg::*;
#(
   parameter int unsigned NUM_SEG = 2,
   parameter int unsigned CODE_W  = 8,
   localparam int unsigned SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ob_valid,
   input  logic               ob_lock,
   input  logic               ob_mem_rd,
   input  logic               ob_internal,
   input  logic [SEG_W-1:0]   ob_seg,
   input  logic               rsp_trdy,
   input  logic               rsp_retry,
   input  logic               rsp_mabort,
   input  logic               rsp_tabort,
   input  logic               rsp_is_rd,
   input  logic [SEG_W-1:0]   rsp_seg,
   input  logic               up_unlock,
   input  logic               cpl_sent,
   input  logic [NUM_SEG-1:0] ib_mem_req,
   output logic [NUM_SEG-1:0] seg_locked,
   output logic [NUM_SEG-1:0] lock_drive,
   output logic [NUM_SEG-1:0] ib_retry,
   output logic [NUM_SEG-1:0] up_block,
   output logic               apic_block,
   output logic               pf_stop,
   output logic               abort_valid,
   output logic [CODE_W-1:0]  abort_code
);
   if (NUM_SEG < 2) begin : g_chk_seg
      $error("bus_lock_ctrl: NUM_SEG must be at least 2");
   end
   if (CODE_W < 1) begin : g_chk_code
      $error("bus_lock_ctrl: CODE_W must be at least 1");
   end

   lk_state_e        state;
   logic [SEG_W-1:0] owner;
   logic             start_ok;

   lock_fsm #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ob_valid(ob_valid), .ob_lock(ob_lock), .ob_mem_rd(ob_mem_rd),
      .ob_internal(ob_internal), .ob_seg(ob_seg),
      .rsp_trdy(rsp_trdy), .rsp_retry(rsp_retry), .rsp_mabort(rsp_mabort),
      .rsp_tabort(rsp_tabort), .rsp_is_rd(rsp_is_rd), .rsp_seg(rsp_seg),
      .up_unlock(up_unlock), .cpl_sent(cpl_sent),
      .state_o(state), .owner_o(owner), .start_ok(start_ok)
   );

   lock_fanout #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_fanout (
      .clk(clk), .rst_n(rst_n),
      .state(state), .owner(owner), .start_ok(start_ok),
      .ob_valid(ob_valid), .ob_seg(ob_seg), .ib_mem_req(ib_mem_req),
      .seg_locked(seg_locked), .lock_drive(lock_drive), .ib_retry(ib_retry),
      .up_block(up_block), .apic_block(apic_block), .pf_stop(pf_stop)
   );

   abort_encoder #(.CODE_W(CODE_W)) u_abort (
      .clk(clk), .rst_n(rst_n),
      .rsp_mabort(rsp_mabort), .rsp_tabort(rsp_tabort),
      .abort_valid(abort_valid), .abort_code(abort_code)
   );

   // R4: prefetch stop and interrupt hold track the lock together
   a_r4_pf_tracks_lock: assert property (@(posedge clk) disable iff (!rst_n)
      pf_stop == (seg_locked != '0));
endmodule

// File: tb/bus_lock_ctrl_tb.sv
`timescale 1ns/100ps
module bus_lock_ctrl_tb;
   localparam int NUM_SEG = 2;
   localparam int CODE_W  = 8;
   localparam int NV      = 19;

   logic clk = 1'b0;
   logic rst_n;
   logic ob_valid, ob_lock, ob_mem_rd, ob_internal, ob_seg;
   logic rsp_trdy, rsp_retry, rsp_mabort, rsp_tabort, rsp_is_rd, rsp_seg;
   logic up_unlock, cpl_sent;
   logic [NUM_SEG-1:0] ib_mem_req;
   logic [NUM_SEG-1:0] seg_locked, lock_drive, ib_retry, up_block;
   logic apic_block, pf_stop, abort_valid;
   logic [CODE_W-1:0] abort_code;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   bus_lock_ctrl #(.NUM_SEG(NUM_SEG), .CODE_W(CODE_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ob_valid(ob_valid), .ob_lock(ob_lock), .ob_mem_rd(ob_mem_rd),
      .ob_internal(ob_internal), .ob_seg(ob_seg),
      .rsp_trdy(rsp_trdy), .rsp_retry(rsp_retry), .rsp_mabort(rsp_mabort),
      .rsp_tabort(rsp_tabort), .rsp_is_rd(rsp_is_rd), .rsp_seg(rsp_seg),
      .up_unlock(up_unlock), .cpl_sent(cpl_sent), .ib_mem_req(ib_mem_req),
      .seg_locked(seg_locked), .lock_drive(lock_drive), .ib_retry(ib_retry),
      .up_block(up_block), .apic_block(apic_block), .pf_stop(pf_stop),
      .abort_valid(abort_valid), .abort_code(abort_code)
   );

   // bits: [15]ov [14]olock [13]ord [12]oint [11]oseg | [10]trdy [9]retry [8]ma
   // [7]ta [6]rsp_rd [5]rseg | [4]unlock [3]cpl | [2:1]exp seg_locked [0]exp pf_stop
   localparam logic [15:0] VEC [NV] = '{
      16'b00000_000000_00_000, // 0  idle, R13 base
      16'b11100_000000_00_000, // 1  R1 locked read seg0 -> pending only
      16'b00000_100000_00_011, // 2  R1 trdy seg0 -> locked
      16'b00000_000000_10_000, // 3  R2 unlock
      16'b11101_000000_00_000, // 4  R11 locked read seg1
      16'b00000_010001_00_000, // 5  R11 retry -> idle
      16'b00000_100001_00_000, // 6  R11 late trdy, no lock
      16'b11110_000000_00_000, // 7  R10 internal target
      16'b00000_100000_00_000, // 8  R10 trdy ignored
      16'b11001_000000_00_000, // 9  R10 locked non-read
      16'b00000_100001_00_000, // 10 R10 trdy ignored
      16'b11101_000000_00_000, // 11 R1 locked read seg1
      16'b00000_100001_00_101, // 12 R1 seg1 locked
      16'b11100_000000_00_101, // 13 R12 other seg request ignored
      16'b00000_100000_00_101, // 14 R12 other seg trdy ignored
      16'b00000_000101_00_101, // 15 R8 write target abort keeps lock
      16'b00000_001011_00_101, // 16 R7 read master abort -> drain
      16'b00000_000000_00_101, // 17 R7 still held
      16'b00000_000000_01_000  // 18 R7 cpl sent -> released
   };
   localparam int TAG [NV] = '{13,1,1,2,11,11,11,10,10,10,10,1,1,12,12,8,7,7,7};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      ob_valid = 0; ob_lock = 0; ob_mem_rd = 0; ob_internal = 0; ob_seg = 0;
      rsp_trdy = 0; rsp_retry = 0; rsp_mabort = 0; rsp_tabort = 0;
      rsp_is_rd = 0; rsp_seg = 0; up_unlock = 0; cpl_sent = 0; ib_mem_req = '0;
   endtask

   task automatic step();
      @(negedge clk);
      clear_in();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      clear_in();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R13: reset state
      check("R13 seg_locked", 32'(seg_locked), 0);
      check("R13 pf_stop", 32'(pf_stop), 0);
      check("R13 abort_valid", 32'(abort_valid), 0);
      check("R6 apic_block idle", 32'(apic_block), 0);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         string tg;
         v = VEC[i];
         ob_valid = v[15]; ob_lock = v[14]; ob_mem_rd = v[13]; ob_internal = v[12];
         ob_seg = v[11]; rsp_trdy = v[10]; rsp_retry = v[9]; rsp_mabort = v[8];
         rsp_tabort = v[7]; rsp_is_rd = v[6]; rsp_seg = v[5];
         up_unlock = v[4]; cpl_sent = v[3];
         step();
         tg = $sformatf("R%0d vec%0d", TAG[i], i);
         check({tg, " seg_locked"}, 32'(seg_locked), 32'(v[2:1]));
         check({tg, " pf_stop"}, 32'(pf_stop), 32'(v[0]));
      end

      // lock segment 0 for the combinational checks
      ob_valid = 1; ob_lock = 1; ob_mem_rd = 1; ob_seg = 0;
      #0.5;
      check("R5 lock_drive on locked read start", 32'(lock_drive), 32'h1);
      step();
      rsp_trdy = 1; rsp_seg = 0;
      step();
      check("R1 seg0 locked", 32'(seg_locked), 32'h1);
      // R5: unlocked cycle to locked segment still drives the lock line
      ob_valid = 1; ob_seg = 0; ib_mem_req = 2'b11;
      #0.5;
      check("R5 lock_drive seg0", 32'(lock_drive), 32'h1);
      check("R3 ib_retry", 32'(ib_retry), 32'h1);
      check("R6 up_block", 32'(up_block), 32'h2);
      check("R6 apic_block", 32'(apic_block), 1);
      check("R4 pf_stop held", 32'(pf_stop), 1);
      ob_seg = 1;
      #0.5;
      check("R5 no lock_drive on seg1", 32'(lock_drive), 0);
      step();

      // R9: abort codes on writes to owner (lock kept, R8)
      rsp_tabort = 1; rsp_seg = 0;
      step();
      check("R9 ta valid", 32'(abort_valid), 1);
      check("R9 ta code", 32'(abort_code), 32'h01);
      check("R8 lock kept", 32'(seg_locked), 32'h1);
      rsp_mabort = 1; rsp_tabort = 1; rsp_seg = 0;
      step();
      check("R9 ma priority code", 32'(abort_code), 32'h00);
      step();
      check("R9 valid pulse ends", 32'(abort_valid), 0);
      check("R8 lock still held", 32'(seg_locked), 32'h1);

      // R11: abort on pending read returns to idle
      up_unlock = 1;
      step();
      ob_valid = 1; ob_lock = 1; ob_mem_rd = 1; ob_seg = 1;
      step();
      rsp_mabort = 1; rsp_is_rd = 1; rsp_seg = 1;
      step();
      rsp_trdy = 1; rsp_seg = 1;
      step();
      check("R11 abort on pending", 32'(seg_locked), 0);

      // R13: reset in the middle of a lock
      ob_valid = 1; ob_lock = 1; ob_mem_rd = 1; ob_seg = 1;
      step();
      rsp_trdy = 1; rsp_seg = 1; rsp_tabort = 1;
      step();
      check("R1 seg1 locked", 32'(seg_locked), 32'h2);
      rst_n = 0;
      step();
      check("R13 mid reset seg_locked", 32'(seg_locked), 0);
      check("R13 mid reset pf_stop", 32'(pf_stop), 0);
      check("R13 mid reset abort_valid", 32'(abort_valid), 0);
      rst_n = 1;
      step();
      finish_run();
   end
endmodule